// File: doc/BRIEF.md
# Descriptor Completion Retirement Tracker

This block follows a circular ring of transmit descriptors and works out which posted packets a DMA engine has finished with. The engine reports how far it has read through the ring as a hardware head index. The tracker keeps its own software head and walks it toward the hardware head one ring slot per clock cycle, wrapping at the ring size. Each slot it walks past counts as one removed descriptor.

Every packet that software posts is pushed into an in-flight FIFO as a tag and the ring index just past its last descriptor. When the walking head lands exactly on the end index of the oldest in-flight packet, that packet is reported complete with an OK status. Each cycle in which the head moves also raises a notification that carries the number of free ring slots.

An abort drains the in-flight FIFO one packet per cycle, reporting each as aborted. After the drain the tracker makes the removed count equal to the added count and clears the head, tail and generation. Scanning happens only while the engine is marked as running.

Top module: `descriptor_retire_tracker`

## Requirements
- R1: In a cycle where `run_en` is 1, no abort is pending or draining, and `sw_head` differs from `hw_head`, `sw_head` advances by one and wraps from RING_DEPTH-1 to 0, and `removed_cnt` increments by one. In any other cycle outside the post-drain reset, neither changes.
- R2: When the advanced head equals the end index of the oldest in-flight packet, that packet is popped. In the following cycle `done_valid` is 1, `done_tag` is its tag and `done_status` is 0 (OK). Packets retire in push order, and at most one report is issued per cycle.
- R3: In the cycle after each head advance, `avail_valid` is 1 and `avail_free` equals RING_DEPTH-1-(added-removed), computed from the counter values after that edge. Otherwise `avail_valid` is 0.
- R4: When `abort` is 1 while the tracker is live, the tracker enters a drain. On each following cycle one in-flight packet is reported, oldest first, with `done_status` 1 (aborted). During the drain and in the abort cycle `push_ready` is 0, and pushes are not recorded.
- R5: On the cycle after the drain finds the FIFO empty, `removed_cnt` equals `added_cnt`, and `sw_head`, `ring_tail` and `ring_gen` are 0.
- R6: While `run_en` is 0, `sw_head` and `removed_cnt` hold, and no completion or availability report is issued, whatever `hw_head` does.
- R7: The in-flight FIFO holds FIFO_DEPTH packets (default 64). `push_ready` is 0 whenever it holds that many, and a push is then refused, even in a cycle that also pops.
- R8: An accepted push (`push_valid` and `push_ready`) adds `push_ndesc` to `added_cnt` and sets `ring_tail` to `push_end`. It also increments the 2-bit `ring_gen` when `push_start`+`push_ndesc` reaches or passes RING_DEPTH.
- R9: After reset, `sw_head`, `ring_tail`, `ring_gen`, `removed_cnt` and `added_cnt` are 0, `free_cnt` is RING_DEPTH-1, and `done_valid` and `avail_valid` are 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| run_en | input | 1 | Engine is in the running state; enables scanning |
| hw_head | input | IDX_W | Ring index reported by the engine as consumed up to |
| abort | input | 1 | Start an abort drain |
| push_valid | input | 1 | Record a newly posted packet |
| push_tag | input | TAG_W | Tag of the posted packet |
| push_start | input | IDX_W | Ring index of the packet's first descriptor |
| push_end | input | IDX_W | Ring index just past the packet's last descriptor |
| push_ndesc | input | IDX_W+1 | Descriptor count of the packet |
| push_ready | output | 1 | Push will be accepted this cycle |
| done_valid | output | 1 | A completion report is present |
| done_tag | output | TAG_W | Tag of the reported packet |
| done_status | output | 1 | 0 = OK, 1 = aborted |
| avail_valid | output | 1 | Free-space notification |
| avail_free | output | CNT_W | Free slots carried by the notification |
| sw_head | output | IDX_W | Software head index |
| ring_tail | output | IDX_W | End index of the latest accepted packet |
| ring_gen | output | 2 | Ring generation count |
| removed_cnt | output | CNT_W | Descriptors retired |
| added_cnt | output | CNT_W | Descriptors posted |
| free_cnt | output | CNT_W | RING_DEPTH-1-(added-removed) |

## Verification
The bench sends packets whose end index is exactly 0, so retirement has to match at the wrap. A design that compared against RING_DEPTH instead would never retire such a packet, and every later packet would stall behind it. It also moves the hardware head forward by several slots at once. A design that jumped the software head would skip end indices and lose completions or reports.

The bench fills the FIFO to 64 packets and then tries one more push. A design with an off-by-one full flag would overwrite the oldest entry, so the drain that follows would report the wrong tags. The bench also asserts aborts in the middle of random traffic. A design that skipped the counter resync or kept scanning during the drain would leave `removed_cnt` different from `added_cnt`, or would report OK for a packet that should be aborted.

// File: rtl/retire_pkg.sv
package retire_pkg;
  typedef enum logic {
    TRK_LIVE  = 1'b0,
    TRK_DRAIN = 1'b1
  } trk_state_e;

  localparam logic STAT_OK    = 1'b0;
  localparam logic STAT_ABORT = 1'b1;
endpackage

// File: rtl/retire_fifo.sv
module retire_fifo #(
  parameter int DEPTH = 64,
  parameter int W     = 12
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic         push,
  input  logic [W-1:0] wdata,
  input  logic         pop,
  output logic [W-1:0] rdata,
  output logic         empty,
  output logic         full
);
  localparam int PTR_W = $clog2(DEPTH);
  localparam int CNT_W = PTR_W + 1;

  logic [W-1:0]     mem [DEPTH];
  logic [PTR_W-1:0] wr_q, wr_d, rd_q, rd_d;
  logic [CNT_W-1:0] cnt_q, cnt_d;

  assign empty = (cnt_q == '0);
  assign full  = (cnt_q == CNT_W'(DEPTH));
  assign rdata = mem[rd_q];

  always_comb begin
    wr_d  = wr_q;
    rd_d  = rd_q;
    cnt_d = cnt_q;
    if (push) wr_d = wr_q + 1'b1;
    if (pop)  rd_d = rd_q + 1'b1;
    if (push && !pop) cnt_d = cnt_q + 1'b1;
    else if (pop && !push) cnt_d = cnt_q - 1'b1;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      wr_q  <= '0;
      rd_q  <= '0;
      cnt_q <= '0;
    end else begin
      wr_q  <= wr_d;
      rd_q  <= rd_d;
      cnt_q <= cnt_d;
    end
  end

  always_ff @(posedge clk) begin
    if (push) mem[wr_q] <= wdata;
  end

  assert_no_overflow_R7: assert property (@(posedge clk) disable iff (!rst_n)
    full |-> !push);
  assert_no_underflow_R2: assert property (@(posedge clk) disable iff (!rst_n)
    empty |-> !pop);
  assert_count_bound_R7: assert property (@(posedge clk) disable iff (!rst_n)
    cnt_q <= CNT_W'(DEPTH));
endmodule

// File: rtl/ring_head.sv
module ring_head #(
  parameter int RING_DEPTH = 16
) (
  input  logic                          clk,
  input  logic                          rst_n,
  input  logic                          step,
  input  logic                          clear,
  output logic [$clog2(RING_DEPTH)-1:0] head,
  output logic [$clog2(RING_DEPTH)-1:0] head_next
);
  localparam int IDX_W = $clog2(RING_DEPTH);
  localparam logic [IDX_W-1:0] LAST_IDX = IDX_W'(RING_DEPTH - 1);

  logic [IDX_W-1:0] head_q, head_d;

  assign head      = head_q;
  assign head_next = (head_q == LAST_IDX) ? '0 : head_q + 1'b1;

  always_comb begin
    head_d = head_q;
    if (clear)     head_d = '0;
    else if (step) head_d = head_next;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) head_q <= '0;
    else        head_q <= head_d;
  end

  assert_hold_when_idle_R1: assert property (@(posedge clk) disable iff (!rst_n)
    (!step && !clear) |=> $stable(head));
  assert_clear_zero_R5: assert property (@(posedge clk) disable iff (!rst_n)
    clear |=> (head == '0));
endmodule

// File: rtl/descriptor_retire_tracker.sv
module descriptor_retire_tracker #(
  parameter int RING_DEPTH = 16,
  parameter int FIFO_DEPTH = 64,
  parameter int TAG_W      = 8,
  parameter int CNT_W      = 16
) (
  input  logic                          clk,
  input  logic                          rst_n,
  input  logic                          run_en,
  input  logic [$clog2(RING_DEPTH)-1:0] hw_head,
  input  logic                          abort,
  input  logic                          push_valid,
  input  logic [TAG_W-1:0]              push_tag,
  input  logic [$clog2(RING_DEPTH)-1:0] push_start,
  input  logic [$clog2(RING_DEPTH)-1:0] push_end,
  input  logic [$clog2(RING_DEPTH):0]   push_ndesc,
  output logic                          push_ready,
  output logic                          done_valid,
  output logic [TAG_W-1:0]              done_tag,
  output logic                          done_status,
  output logic                          avail_valid,
  output logic [CNT_W-1:0]              avail_free,
  output logic [$clog2(RING_DEPTH)-1:0] sw_head,
  output logic [$clog2(RING_DEPTH)-1:0] ring_tail,
  output logic [1:0]                    ring_gen,
  output logic [CNT_W-1:0]              removed_cnt,
  output logic [CNT_W-1:0]              added_cnt,
  output logic [CNT_W-1:0]              free_cnt
);
  import retire_pkg::*;

  localparam int IDX_W   = $clog2(RING_DEPTH);
  localparam int ENTRY_W = TAG_W + IDX_W;
  localparam int SUM_W   = IDX_W + 2;
  localparam logic [CNT_W-1:0] SPACE = CNT_W'(RING_DEPTH - 1);

  trk_state_e st_q, st_d;
  logic [CNT_W-1:0] removed_q, removed_d, added_q, added_d, avail_free_q, avail_free_d;
  logic [IDX_W-1:0] tail_q, tail_d;
  logic [1:0]       gen_q, gen_d;
  logic             done_v_q, done_v_d, done_st_q, done_st_d, avail_v_q, avail_v_d;
  logic [TAG_W-1:0] done_tag_q, done_tag_d;

  logic [IDX_W-1:0]   head, head_next;
  logic [ENTRY_W-1:0] fifo_wdata, fifo_rdata;
  logic               fifo_empty, fifo_full;
  logic [TAG_W-1:0]   old_tag;
  logic [IDX_W-1:0]   old_end;
  logic               scan, push_en, retire_hit, drain_pop, drain_done, pop, wraps;

  assign fifo_wdata       = {push_tag, push_end};
  assign {old_tag, old_end} = fifo_rdata;

  assign scan       = (st_q == TRK_LIVE) && !abort && run_en && (head != hw_head);
  assign push_ready = (st_q == TRK_LIVE) && !abort && !fifo_full;
  assign push_en    = push_valid && push_ready;
  assign retire_hit = scan && !fifo_empty && (head_next == old_end);
  assign drain_pop  = (st_q == TRK_DRAIN) && !fifo_empty;
  assign drain_done = (st_q == TRK_DRAIN) && fifo_empty;
  assign pop        = retire_hit || drain_pop;
  assign wraps      = ({2'b00, push_start} + {1'b0, push_ndesc}) >= SUM_W'(RING_DEPTH);

  ring_head #(.RING_DEPTH(RING_DEPTH)) u_head (
    .clk       (clk),
    .rst_n     (rst_n),
    .step      (scan),
    .clear     (drain_done),
    .head      (head),
    .head_next (head_next)
  );

  retire_fifo #(.DEPTH(FIFO_DEPTH), .W(ENTRY_W)) u_fifo (
    .clk   (clk),
    .rst_n (rst_n),
    .push  (push_en),
    .wdata (fifo_wdata),
    .pop   (pop),
    .rdata (fifo_rdata),
    .empty (fifo_empty),
    .full  (fifo_full)
  );

  always_comb begin
    st_d = st_q;
    if (st_q == TRK_LIVE && abort) st_d = TRK_DRAIN;
    else if (drain_done)           st_d = TRK_LIVE;

    removed_d = removed_q;
    if (drain_done) removed_d = added_q;
    else if (scan)  removed_d = removed_q + 1'b1;

    added_d = added_q;
    tail_d  = tail_q;
    gen_d   = gen_q;
    if (drain_done) begin
      tail_d = '0;
      gen_d  = '0;
    end else if (push_en) begin
      added_d = added_q + CNT_W'(push_ndesc);
      tail_d  = push_end;
      if (wraps) gen_d = gen_q + 1'b1;
    end

    done_v_d     = pop;
    done_tag_d   = pop ? old_tag : done_tag_q;
    done_st_d    = drain_pop ? STAT_ABORT : STAT_OK;
    avail_v_d    = scan;
    avail_free_d = scan ? (SPACE - (added_d - removed_d)) : avail_free_q;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      st_q         <= TRK_LIVE;
      removed_q    <= '0;
      added_q      <= '0;
      tail_q       <= '0;
      gen_q        <= '0;
      done_v_q     <= 1'b0;
      done_tag_q   <= '0;
      done_st_q    <= STAT_OK;
      avail_v_q    <= 1'b0;
      avail_free_q <= '0;
    end else begin
      st_q         <= st_d;
      removed_q    <= removed_d;
      added_q      <= added_d;
      tail_q       <= tail_d;
      gen_q        <= gen_d;
      done_v_q     <= done_v_d;
      done_tag_q   <= done_tag_d;
      done_st_q    <= done_st_d;
      avail_v_q    <= avail_v_d;
      avail_free_q <= avail_free_d;
    end
  end

  assign done_valid  = done_v_q;
  assign done_tag    = done_tag_q;
  assign done_status = done_st_q;
  assign avail_valid = avail_v_q;
  assign avail_free  = avail_free_q;
  assign sw_head     = head;
  assign ring_tail   = tail_q;
  assign ring_gen    = gen_q;
  assign removed_cnt = removed_q;
  assign added_cnt   = added_q;
  assign free_cnt    = SPACE - (added_q - removed_q);

  assert_removed_step_R1: assert property (@(posedge clk) disable iff (!rst_n)
    (st_q == TRK_LIVE && $past(st_q) == TRK_LIVE) |-> ((removed_q - $past(removed_q)) <= CNT_W'(1)));
  assert_drain_status_R4: assert property (@(posedge clk) disable iff (!rst_n)
    (done_valid && $past(st_q) == TRK_DRAIN) |-> (done_status == STAT_ABORT));
  assert_resync_R5: assert property (@(posedge clk) disable iff (!rst_n)
    ($past(st_q) == TRK_DRAIN && st_q == TRK_LIVE) |-> (removed_cnt == added_cnt && ring_tail == '0 && ring_gen == 2'b00));
  assert_gate_on_run_R6: assert property (@(posedge clk) disable iff (!rst_n)
    avail_valid |-> $past(run_en));
  assert_no_push_in_drain_R4: assert property (@(posedge clk) disable iff (!rst_n)
    (st_q == TRK_DRAIN) |=> (added_cnt == $past(added_cnt)));
endmodule

// File: tb/tb_descriptor_retire_tracker.sv
`timescale 1ns/1ps
module tb_descriptor_retire_tracker;
  localparam int RD = 16;
  localparam int FD = 64;

  logic        clk, rst_n, run_i, abort_i, pv_i;
  logic [3:0]  hw_i, ps_i, pe_i;
  logic [4:0]  pn_i;
  logic [7:0]  pt_i;
  logic        push_ready, done_valid, done_status, avail_valid;
  logic [7:0]  done_tag;
  logic [15:0] avail_free, removed_cnt, added_cnt, free_cnt;
  logic [3:0]  sw_head, ring_tail;
  logic [1:0]  ring_gen;

  descriptor_retire_tracker dut (
    .clk(clk), .rst_n(rst_n), .run_en(run_i), .hw_head(hw_i), .abort(abort_i),
    .push_valid(pv_i), .push_tag(pt_i), .push_start(ps_i), .push_end(pe_i),
    .push_ndesc(pn_i), .push_ready(push_ready), .done_valid(done_valid),
    .done_tag(done_tag), .done_status(done_status), .avail_valid(avail_valid),
    .avail_free(avail_free), .sw_head(sw_head), .ring_tail(ring_tail),
    .ring_gen(ring_gen), .removed_cnt(removed_cnt), .added_cnt(added_cnt),
    .free_cnt(free_cnt)
  );

  initial clk = 1'b0;
  always #5 clk = ~clk;

  int nchk = 0, nfail = 0;
  bit finished = 0;

  // bench model state
  int m_head, m_tail, m_gen, m_st;
  logic [15:0] m_rem, m_add, e_free;
  int q_tag[$], q_end[$];
  bit e_dv, e_ds, e_av, last_drain_pop;
  int e_dt;
  int hw_pos;
  logic [15:0] hw_cons;
  int next_tag = 1;

  task automatic chk(string req, string what, int act, int exp);
    nchk++;
    if (act != exp) begin
      nfail++;
      $display("FAIL %s %s actual=%0d expected=%0d", req, what, act, exp);
    end
  endtask

  function automatic logic [15:0] model_free();
    return 16'(RD - 1) - (m_add - m_rem);
  endfunction

  task automatic model_edge();
    bit ready, scan;
    int nh;
    ready = (m_st == 0) && !abort_i && (q_tag.size() < FD);
    e_dv = 0; e_av = 0; last_drain_pop = 0;
    if (m_st == 0) begin
      if (abort_i) m_st = 1;
      else begin
        scan = run_i && (m_head != int'(hw_i));
        if (scan) begin
          nh = (m_head + 1) % RD;
          if (q_tag.size() > 0 && q_end[0] == nh) begin
            e_dv = 1; e_ds = 0; e_dt = q_tag.pop_front(); void'(q_end.pop_front());
          end
          m_head = nh;
          m_rem = m_rem + 16'd1;
          e_av = 1;
        end
        if (pv_i && ready) begin
          q_tag.push_back(int'(pt_i)); q_end.push_back(int'(pe_i));
          m_add = m_add + 16'(pn_i);
          m_tail = int'(pe_i);
          if (int'(ps_i) + int'(pn_i) >= RD) m_gen = (m_gen + 1) % 4;
        end
        if (scan) e_free = model_free();
      end
    end else begin
      if (q_tag.size() > 0) begin
        e_dv = 1; e_ds = 1; e_dt = q_tag.pop_front(); void'(q_end.pop_front());
        last_drain_pop = 1;
      end else begin
        m_rem = m_add; m_head = 0; m_tail = 0; m_gen = 0; m_st = 0;
      end
    end
  endtask

  task automatic compare_all();
    bit exp_ready;
    exp_ready = (m_st == 0) && !abort_i && (q_tag.size() < FD);
    chk("R1", "sw_head", int'(sw_head), m_head);
    chk("R1", "removed_cnt", int'(removed_cnt), int'(m_rem));
    chk("R8", "added_cnt", int'(added_cnt), int'(m_add));
    chk("R8", "ring_tail", int'(ring_tail), m_tail);
    chk("R8", "ring_gen", int'(ring_gen), m_gen);
    chk("R3", "free_cnt", int'(free_cnt), int'(model_free()));
    chk("R7", "push_ready", int'(push_ready), int'(exp_ready));
    chk(last_drain_pop ? "R4" : "R2", "done_valid", int'(done_valid), int'(e_dv));
    if (e_dv) begin
      chk(last_drain_pop ? "R4" : "R2", "done_tag", int'(done_tag), e_dt);
      chk(last_drain_pop ? "R4" : "R2", "done_status", int'(done_status), int'(e_ds));
    end
    chk(run_i ? "R3" : "R6", "avail_valid", int'(avail_valid), int'(e_av));
    if (e_av) chk("R3", "avail_free", int'(avail_free), int'(e_free));
  endtask

  task automatic step();
    @(posedge clk);
    model_edge();
    @(negedge clk);
    compare_all();
  endtask

  task automatic post(int nd);
    pv_i = 1'b1;
    pt_i = 8'(next_tag);
    next_tag++;
    ps_i = 4'(m_tail);
    pn_i = 5'(nd);
    pe_i = 4'((m_tail + nd) % RD);
  endtask

  task automatic idle_push();
    pv_i = 1'b0; pt_i = '0; ps_i = '0; pe_i = '0; pn_i = '0;
  endtask

  task automatic summary();
    $display("  *** SUMMARY: %0d compared / %0d mismatched ***", nchk, nfail);
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    if (!finished) begin
      nfail++;
      $display("FAIL watchdog all-requirements actual=timeout expected=finish");
      summary();
      $finish;
    end
  end

  initial begin
    void'($urandom(32'd20240611));
    rst_n = 1'b0; run_i = 1'b0; abort_i = 1'b0; hw_i = '0;
    idle_push();
    m_head = 0; m_tail = 0; m_gen = 0; m_st = 0; m_rem = '0; m_add = '0;
    e_dv = 0; e_ds = 0; e_dt = 0; e_av = 0; e_free = '0; last_drain_pop = 0;
    hw_pos = 0; hw_cons = '0;
    repeat (3) @(negedge clk);
    // R9 reset state
    chk("R9", "sw_head", int'(sw_head), 0);
    chk("R9", "ring_tail", int'(ring_tail), 0);
    chk("R9", "ring_gen", int'(ring_gen), 0);
    chk("R9", "removed_cnt", int'(removed_cnt), 0);
    chk("R9", "added_cnt", int'(added_cnt), 0);
    chk("R9", "free_cnt", int'(free_cnt), RD - 1);
    chk("R9", "done_valid", int'(done_valid), 0);
    chk("R9", "avail_valid", int'(avail_valid), 0);
    rst_n = 1'b1;

    // directed: three packets posted while stopped, hw head jumps ahead (R6, R1, R2)
    post(3); step();
    post(2); step();
    post(4); step();
    idle_push();
    hw_i = 4'd9; hw_pos = 9; hw_cons = 16'd9;
    repeat (3) step();
    chk("R6", "head frozen while stopped", int'(sw_head), 0);
    run_i = 1'b1;
    repeat (12) step();
    chk("R1", "head caught up", int'(sw_head), 9);
    chk("R2", "all retired", int'(q_tag.size()), 0);

    // directed: packet ending exactly at index 0 (R2 wrap, R8 generation)
    post(7); step();
    idle_push();
    chk("R8", "generation after wrap", int'(ring_gen), 1);
    hw_i = 4'd0; hw_pos = 0; hw_cons = m_add;
    repeat (9) step();
    chk("R2", "wrap retire", int'(sw_head), 0);

    // constrained random traffic with occasional aborts
    for (int i = 0; i < 3000; i++) begin
      int lag, k, nd;
      abort_i = 1'b0;
      idle_push();
      run_i = ($urandom % 8) != 0;
      if (m_st == 0 && ($urandom % 150) == 0) begin
        abort_i = 1'b1;
        hw_i = '0; hw_pos = 0; hw_cons = m_add;
      end else begin
        lag = int'(m_add - hw_cons);
        if (lag > 0 && ($urandom % 3) == 0) begin
          k = 1 + int'($urandom % 4);
          if (k > lag) k = lag;
          hw_pos = (hw_pos + k) % RD;
          hw_cons = hw_cons + 16'(k);
          hw_i = 4'(hw_pos);
        end
        nd = 1 + int'($urandom % 4);
        if (($urandom % 2) == 0 && nd <= int'(model_free()) && m_st == 0) post(nd);
        else if (m_st == 1 && ($urandom % 2) == 0) post(1);
      end
      step();
    end

    // drain everything, then fill the FIFO to capacity (R7) and abort (R4, R5)
    abort_i = 1'b1; idle_push(); step();
    abort_i = 1'b0;
    while (m_st != 0) step();
    chk("R5", "resync removed", int'(removed_cnt), int'(added_cnt));
    chk("R5", "head zero", int'(sw_head), 0);
    hw_i = '0; run_i = 1'b0;
    for (int n = 0; n < FD; n++) begin
      post(1); step();
    end
    post(1);
    #1;
    chk("R7", "ready low when full", int'(push_ready), 0);
    step();
    chk("R7", "entries held", int'(q_tag.size()), FD);
    idle_push();
    abort_i = 1'b1; step();
    abort_i = 1'b0;
    post(1);
    for (int n = 0; n < FD; n++) begin
      step();
      chk("R4", "drain status", int'(done_status), 1);
    end
    idle_push();
    step(); step();
    chk("R5", "removed equals added", int'(removed_cnt), int'(added_cnt));
    chk("R5", "tail zero", int'(ring_tail), 0);
    chk("R5", "gen zero", int'(ring_gen), 0);

    finished = 1;
    summary();
    $finish;
  end
endmodule